// File: doc/BRIEF.md
# Dual-Mode Peripheral Clock Divider

This block derives one peripheral clock from one of four source clocks. The whole block runs on a single fast system clock. Each source clock is presented to it as a one-cycle strobe that marks that source's rising edge. The output is a registered level on the system clock. Its rising edges stand for the rising edges of the divided peripheral clock.

A control word holds a source select and a phase value. An external mode bit decides how the phase value is used. In fractional mode, a phase accumulator adds the phase value on every selected source edge. The output rate is then the source rate times phase/64, and a phase of zero passes the source through undivided. In integer mode, a counter divides the source by (phase+1).

A high-active disable input silences the output. New select, mode or phase values are adopted only at the end of an output period, or at any time while the output is disabled. This way a running period never ends in a runt.

Top module: `periph_clk_div`

## Requirements
- R1: The select field `ctrl_word[9:8]` picks the source: value k (0..3) uses the strobe `src_stb[k]`.
- R2: The phase field is `ctrl_word[5:0]`. With `div_int_mode`=0 and phase 0, the output goes high for exactly one clock, one clock after each selected source strobe. The output therefore has one rising edge per source edge.
- R3: With `div_int_mode`=0 and phase P in 1..32, the output gives P rising edges per 64 selected source edges on average. The edges come from the top bit of a 6-bit accumulator that adds P on each source edge.
- R4: With `div_int_mode`=1 and phase N, the output gives one rising edge per N+1 selected source edges. N=0 behaves as in R2.
- R5: In integer mode with N≥1, each period is low for the first ceil((N+1)/2) source edges and high for the last floor((N+1)/2). Each level change appears one clock after the source strobe that causes it.
- R6: While `clk_off` is high, the output is low from the next clock edge on. Both divide engines restart from zero when the disable is released.
- R7: Control word bits other than [9:8] and [5:0] have no effect on the output.
- R8: A new select, mode or phase is adopted only on the source edge that ends the current output period, or on any clock while `clk_off` is high. A period in progress completes with the old settings.
- R9: Reset (`rst_n` low, synchronous) drives the output low. It also clears the adopted settings to zero, so after reset the block passes source 0 through in fractional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes and the output are on this clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_stb | input | 4 | One-cycle rising-edge strobes of the four source clocks |
| ctrl_word | input | 32 | Control word: select in [9:8], phase in [5:0], rest reserved |
| div_int_mode | input | 1 | 0 = fractional (accumulator) mode, 1 = integer (N+1) mode |
| clk_off | input | 1 | High forces the output low and permits immediate reconfiguration |
| pclk_o | output | 1 | Divided peripheral clock level |

## Verification
The disable input and the period-end reload both write the adopted settings, and both can fall on the same clock. That happens when `clk_off` rises on the very source strobe that closes an output period, and a new control word is presented in that cycle. The bench sweeps the onset of a short disable pulse across twelve consecutive clock offsets, changing mode and phase at each onset. This walks the collision through every position in the period. A behavioural cycle model in the bench predicts the output on every clock, so a wrong settle point or a missed forced-low shows up as a mismatch in the exact cycle. A separate check times one high phase that is interrupted by a reconfiguration and expects its full old length.

// File: rtl/pcd_pkg.sv
// Package: shared types for the peripheral clock divider.
// Assumes: nothing beyond IEEE 1800-2017.
package pcd_pkg;
    // Divide engine choice taken from the external mode bit.
    typedef enum logic {
        DIV_FRAC = 1'b0,
        DIV_INT  = 1'b1
    } div_mode_e;

    // Default field geometry of the control word.
    localparam int DEF_PHASE_W = 6;
    localparam int DEF_NSRC    = 4;
    localparam int DEF_CTRL_W  = 32;
    localparam int DEF_SEL_LSB = 8;
endpackage

// File: rtl/pcd_srcmux.sv
// Module: picks the strobe of one source clock.
// Assumes: sel values at or above NSRC select no source (tick stays low).
module pcd_srcmux #(
    parameter int NSRC  = 4,
    parameter int SEL_W = 2
) (
    input  logic [NSRC-1:0]  stb,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    // Decoded one-of-N selection of the source strobe.
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < NSRC; i++) begin
            if (sel == SEL_W'(i)) tick = stb[i];
        end
    end
endmodule

// File: rtl/pcd_frac.sv
// Module: phase-accumulator divider. Adds the phase on every source strobe.
// The level output is the accumulator top bit and wrap flags the carry.
// Assumes: phase at most half of 2**PHASE_W for an exact average rate.
module pcd_frac #(
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic [PHASE_W-1:0] phase,
    output logic               lvl,
    output logic               wrap
);
    logic [PHASE_W-1:0] acc;
    logic [PHASE_W:0]   sum;

    // Next accumulator value with carry bit.
    always_comb sum = {1'b0, acc} + {1'b0, phase};

    assign wrap = tick & sum[PHASE_W];
    assign lvl  = acc[PHASE_W-1];

    // Accumulator register: cleared while idle, advanced on source strobes.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc <= '0;
        else if (clr)   acc <= '0;
        else if (tick)  acc <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/pcd_int.sv
// Module: integer divider by (phase+1). The level is low for the first
// ceil((N+1)/2) source edges of a period and high for the rest.
// Assumes: phase only changes while cleared or on the wrap strobe.
module pcd_int #(
    parameter int PHASE_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               tick,
    input  logic [PHASE_W-1:0] phase,
    output logic               lvl,
    output logic               wrap
);
    logic [PHASE_W-1:0] cnt;
    logic [PHASE_W:0]   period;
    logic [PHASE_W:0]   thresh;
    logic               last;

    // Period length and the position at which the high half starts.
    always_comb begin
        period = {1'b0, phase} + 1'b1;
        thresh = period - (period >> 1);
        last   = (cnt == phase);
    end

    assign wrap = tick & last;
    assign lvl  = ({1'b0, cnt} >= thresh);

    // Position counter: cleared while idle, reloads to zero after the last edge.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (clr)   cnt <= '0;
        else if (tick)  cnt <= last ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/periph_clk_div.sv
// Module: dual-mode peripheral clock divider (top).
// Sources arrive as rising-edge strobes on clk. The output is a registered level.
// Settings are adopted at the end of an output period or while disabled.
// Assumes: each source strobe is at most one cycle wide.
module periph_clk_div
    import pcd_pkg::*;
#(
    parameter int NSRC    = DEF_NSRC,
    parameter int PHASE_W = DEF_PHASE_W,
    parameter int CTRL_W  = DEF_CTRL_W,
    parameter int SEL_LSB = DEF_SEL_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_stb,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              div_int_mode,
    input  logic              clk_off,
    output logic              pclk_o
);
    localparam int SEL_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [SEL_W-1:0]   req_sel;
    logic [PHASE_W-1:0] req_phase;
    logic               unused_rsvd;

    logic [SEL_W-1:0]   act_sel;
    logic [PHASE_W-1:0] act_phase;
    div_mode_e          act_mode;

    logic tick, bypass, period_end, load;
    logic clr_frac, clr_int;
    logic frac_lvl, frac_wrap, int_lvl, int_wrap;
    logic pclk_r;

    // Field extraction; reserved bits are folded away.
    always_comb begin
        req_sel     = ctrl_word[SEL_LSB +: SEL_W];
        req_phase   = ctrl_word[PHASE_W-1:0];
        unused_rsvd = ^ctrl_word;
    end

    pcd_srcmux #(.NSRC(NSRC), .SEL_W(SEL_W)) u_mux (
        .stb  (src_stb),
        .sel  (act_sel),
        .tick (tick)
    );

    // Engine idling and settle-point detection.
    always_comb begin
        bypass     = (act_phase == '0);
        clr_frac   = clk_off | bypass | (act_mode == DIV_INT);
        clr_int    = clk_off | bypass | (act_mode == DIV_FRAC);
        if (bypass)                   period_end = tick;
        else if (act_mode == DIV_INT) period_end = int_wrap;
        else                          period_end = frac_wrap;
        load       = clk_off | period_end;
    end

    pcd_frac #(.PHASE_W(PHASE_W)) u_frac (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_frac),
        .tick  (tick),
        .phase (act_phase),
        .lvl   (frac_lvl),
        .wrap  (frac_wrap)
    );

    pcd_int #(.PHASE_W(PHASE_W)) u_int (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr_int),
        .tick  (tick),
        .phase (act_phase),
        .lvl   (int_lvl),
        .wrap  (int_wrap)
    );

    // Adopted settings: shadowed at the settle point or while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_sel   <= '0;
            act_phase <= '0;
            act_mode  <= DIV_FRAC;
        end else if (load) begin
            act_sel   <= req_sel;
            act_phase <= req_phase;
            act_mode  <= div_mode_e'(div_int_mode);
        end
    end

    // Output register: forced low when disabled, else from the active engine.
    always_ff @(posedge clk) begin
        if (!rst_n)                   pclk_r <= 1'b0;
        else if (clk_off)             pclk_r <= 1'b0;
        else if (bypass)              pclk_r <= tick;
        else if (act_mode == DIV_INT) pclk_r <= int_lvl;
        else                          pclk_r <= frac_lvl;
    end

    assign pclk_o = pclk_r;
endmodule

// File: rtl/pcd_chk.sv
// Checker: temporal properties of the peripheral clock divider, bound to the top.
// Assumes: reset is synchronous and active low.
module pcd_chk #(
    parameter int PHASE_W = 6,
    parameter int SEL_W   = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clk_off,
    input logic               pclk_o,
    input logic [SEL_W-1:0]   req_sel,
    input logic [PHASE_W-1:0] req_phase,
    input logic [SEL_W-1:0]   act_sel,
    input logic [PHASE_W-1:0] act_phase,
    input logic               act_int,
    input logic               int_wrap,
    input logic               frac_wrap,
    input logic               frac_lvl,
    input logic               clr_frac
);
    // R6
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off |=> !pclk_o);

    // R8
    off_adopt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_off |=> (act_phase == $past(req_phase)) && (act_sel == $past(req_sel)));

    // R5
    int_end_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_wrap && !clk_off && act_int && act_phase != '0) |=> pclk_o);

    // R3
    frac_carry_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frac_wrap && !clr_frac && act_phase <= PHASE_W'(1 << (PHASE_W-1))) |=> !frac_lvl);
endmodule

bind periph_clk_div pcd_chk #(.PHASE_W(PHASE_W), .SEL_W(SEL_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_off   (clk_off),
    .pclk_o    (pclk_o),
    .req_sel   (req_sel),
    .req_phase (req_phase),
    .act_sel   (act_sel),
    .act_phase (act_phase),
    .act_int   (act_mode == pcd_pkg::DIV_INT),
    .int_wrap  (int_wrap),
    .frac_wrap (frac_wrap),
    .frac_lvl  (frac_lvl),
    .clr_frac  (clr_frac)
);

// File: tb/sim_periph_clk_div.sv
// Bench: cycle model plus windowed edge counts for the peripheral clock divider.
module sim_periph_clk_div;
    localparam int CLK_NS = 10;
    localparam int WIN    = 4000;
    localparam int SETTLE = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  stb = '0;
    logic [31:0] ctrl = '0;
    logic        imode = 1'b0;
    logic        off = 1'b0;
    logic        pclk;

    int checks = 0;
    int errs = 0;
    bit done = 1'b0;
    int per[4] = '{2, 3, 5, 7};

    periph_clk_div u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .src_stb      (stb),
        .ctrl_word    (ctrl),
        .div_int_mode (imode),
        .clk_off      (off),
        .pclk_o       (pclk)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Source strobe generator: source k ticks every per[k] clocks.
    initial begin
        int c4[4] = '{0, 0, 0, 0};
        forever begin
            @(negedge clk);
            for (int i = 0; i < 4; i++) begin
                c4[i] = (c4[i] + 1) % per[i];
                stb[i] = (c4[i] == 0);
            end
        end
    end

    // Behavioural model state.
    int m_sel = 0, m_mode = 0, m_ph = 0, m_acc = 0, m_cnt = 0, m_out = 0;
    int m_t, m_nout, m_end;
    bit seen_rst = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_mode = 0; m_ph = 0; m_acc = 0; m_cnt = 0; m_out = 0;
            seen_rst = 1'b1;
        end else begin
            m_t = stb[m_sel];
            if (off)             m_nout = 0;
            else if (m_ph == 0)  m_nout = m_t;
            else if (m_mode != 0) m_nout = (m_cnt >= (m_ph + 1) - (m_ph + 1) / 2) ? 1 : 0;
            else                 m_nout = (m_acc >= 32) ? 1 : 0;
            if (m_ph == 0)        m_end = m_t;
            else if (m_mode != 0) m_end = (m_t != 0 && m_cnt == m_ph) ? 1 : 0;
            else                  m_end = (m_t != 0 && m_acc + m_ph >= 64) ? 1 : 0;
            if (off || m_ph == 0 || m_mode == 0) m_cnt = 0;
            else if (m_t != 0) m_cnt = (m_cnt == m_ph) ? 0 : m_cnt + 1;
            if (off || m_ph == 0 || m_mode != 0) m_acc = 0;
            else if (m_t != 0) m_acc = (m_acc + m_ph) % 64;
            if (off || m_end != 0) begin
                m_sel  = int'(ctrl[9:8]);
                m_mode = int'(imode);
                m_ph   = int'(ctrl[5:0]);
            end
            m_out = m_nout;
        end
    end

    // Per-cycle comparison against the model (R2 R5 R8 R9 timing).
    always @(negedge clk) begin
        if (seen_rst && !done)
            chk(pclk === m_out[0], "R2 R5 R8 cycle", int'(pclk), m_out);
    end

    // Window counters.
    int csel = 0;
    bit cnt_clr = 1'b0;
    int rises = 0, ticks = 0, highs = 0;
    logic prev_p = 1'b0;

    always @(posedge clk) begin
        if (cnt_clr) ticks = 0;
        else if (stb[csel]) ticks++;
    end

    always @(negedge clk) begin
        if (cnt_clr) begin
            rises = 0;
            highs = 0;
        end else begin
            if (pclk && !prev_p) rises++;
            if (pclk) highs++;
        end
        prev_p = pclk;
    end

    task automatic measure(input int sel, input bit mode, input int ph, input logic [31:0] rsv,
                           output int r, output int tk, output int hi);
        @(negedge clk);
        ctrl  = rsv | {22'b0, sel[1:0], 2'b0, ph[5:0]};
        imode = mode;
        csel  = sel;
        repeat (SETTLE) @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        repeat (WIN) @(negedge clk);
        r  = rises;
        tk = ticks;
        hi = highs;
    endtask

    function automatic int iabs(input int v);
        return (v < 0) ? -v : v;
    endfunction

    // Watchdog.
    initial begin
        #(CLK_NS * 190000);
        if (!done) begin
            done = 1'b1;
            errs++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        int r, tk, hi, run;
        int fph[4] = '{1, 7, 20, 32};
        int iph[5] = '{0, 1, 2, 5, 63};
        int isel[5] = '{0, 1, 2, 0, 3};

        // R9: reset holds the output low.
        repeat (4) begin
            @(negedge clk);
            chk(pclk == 1'b0, "R9 reset low", int'(pclk), 0);
        end
        rst_n = 1'b1;
        // R9: after reset, source 0 passes through.
        measure(0, 1'b0, 0, 32'h0, r, tk, hi);
        chk(iabs(r - tk) <= 1, "R9 default bypass", r, tk);

        // R1 R2: bypass on every source.
        for (int s = 0; s < 4; s++) begin
            measure(s, 1'b0, 0, 32'h0, r, tk, hi);
            chk(iabs(r - tk) <= 1 && tk > WIN / 8, "R1 R2 bypass rate", r, tk);
            chk(iabs(tk - WIN / per[s]) <= 1, "R1 source tick rate", tk, WIN / per[s]);
        end

        // R3: fractional rates.
        for (int i = 0; i < 4; i++) begin
            measure(0, 1'b0, fph[i], 32'h0, r, tk, hi);
            chk(iabs(r - tk * fph[i] / 64) <= 2, "R3 fractional rate", r, tk * fph[i] / 64);
        end

        // R4: integer rates.
        for (int i = 0; i < 5; i++) begin
            measure(isel[i], 1'b1, iph[i], 32'h0, r, tk, hi);
            chk(iabs(r - tk / (iph[i] + 1)) <= 2, "R4 integer rate", r, tk / (iph[i] + 1));
        end

        // R5: duty cycle, N=4 gives 2/5 high, N=5 gives 3/6 high.
        measure(0, 1'b1, 4, 32'h0, r, tk, hi);
        chk(iabs(hi * 5 - WIN * 2) <= 40, "R5 duty N4", hi, WIN * 2 / 5);
        measure(0, 1'b1, 5, 32'h0, r, tk, hi);
        chk(iabs(hi * 6 - WIN * 3) <= 60, "R5 duty N5", hi, WIN / 2);

        // R7: reserved bits set, fractional 13 must be unchanged.
        measure(0, 1'b0, 13, 32'hFFFF_FCC0, r, tk, hi);
        chk(iabs(r - tk * 13 / 64) <= 2, "R7 reserved ignored", r, tk * 13 / 64);
        ctrl = '0;

        // R6: disable forces low.
        measure(0, 1'b1, 3, 32'h0, r, tk, hi);
        @(negedge clk);
        off = 1'b1;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            chk(pclk == 1'b0, "R6 disabled low", int'(pclk), 0);
        end
        off = 1'b0;
        repeat (100) @(negedge clk);

        // R8: a high phase in progress keeps its old length (N=9 on source 1 -> 15 clocks).
        @(negedge clk);
        ctrl = {22'b0, 2'd1, 2'b0, 6'd9};
        imode = 1'b1;
        repeat (SETTLE) @(negedge clk);
        while (!(pclk && !prev_p)) @(negedge clk);
        ctrl = {22'b0, 2'd1, 2'b0, 6'd1};
        run = 1;
        @(negedge clk);
        while (pclk) begin
            run++;
            @(negedge clk);
        end
        chk(run == 15, "R8 period completes", run, 15);
        repeat (200) @(negedge clk);

        // R6 R8: disable onset swept across period positions, with settings changing.
        for (int o = 0; o < 12; o++) begin
            @(negedge clk);
            ctrl = {22'b0, 2'd0, 2'b0, 6'd2};
            imode = 1'b1;
            repeat (40 + o) @(negedge clk);
            off = 1'b1;
            ctrl = {22'b0, 2'd1, 2'b0, 6'd24};
            imode = 1'b0;
            repeat (3) @(negedge clk);
            off = 1'b0;
            repeat (300) @(negedge clk);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule